// File: doc/BRIEF.md
# Two-Level Interrupt Status Aggregator

This block gathers single-bit event pulses into nine 8-bit latched status groups. Each group has its own enable-mask register. An 8-bit summary register shows which groups hold pending, unmasked events, and one active-high interrupt line goes to the host. A host reads the summary to find the group that needs attention. It then reads that group's status and acknowledges events by writing ones back to the same address.

Two points differ from a flat controller. One summary bit covers two groups: groups 4 and 5 both report on summary bit 4. A second, summary-level mask sits between the summary and the interrupt line. That mask is a register of its own, and no write to a group mask changes it. Registers are reached through a plain 8-bit address and 8-bit data port with separate read and write strobes. Reads are combinational and have no side effects.

The design has no state machine. Every register is a latch-and-clear element, so no states or transitions need naming.

Top module: `irq_agg_top`

## Requirements
- R1: After reset, every status bit is 0, every group mask reads all ones on its used bits (zero elsewhere), the summary mask reads 0xFF, and `irq_o` is low.
- R2: A one-cycle event pulse on a used source sets its status bit on the next clock edge, whether or not the bit is masked. The bit then holds until it is acknowledged.
- R3: Groups 0 to 8 use the low 7, 8, 7, 3, 8, 8, 2, 4 and 5 bits. Unused status and mask bits always read 0, and pulses on unused sources have no effect.
- R4: A write to a group status address clears exactly the bits written as 1. Bits written as 0 keep their value.
- R5: If an event pulse and a clearing write hit the same status bit in the same cycle, the bit stays set.
- R6: Summary bit g is the OR of (status AND NOT mask) over its groups. Bits 0 to 3 cover groups 0 to 3, bit 4 covers groups 4 and 5, and bits 5, 6 and 7 cover groups 6, 7 and 8.
- R7: `irq_o` is high exactly when some summary bit is 1 and the corresponding summary-mask bit is 0. A mask bit of 1 blocks its summary bit.
- R8: The summary mask changes only when its own address is written. Writes to group masks leave it unchanged, and writes to the read-only summary register change nothing.
- R9: The address map is: summary at 0x00 (read-only), summary mask at 0x01, group j status at 0x10+j, and group j mask at 0x20+j. Any other address reads 0.
- R10: Group 7 holds the four GPIO events. Its pending events reach `irq_o` only once summary-mask bit 6 is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| evt_i | input | 72 | Event pulses; group j uses bits [8j+7:8j] |
| reg_addr | input | 8 | Register address |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rd | input | 1 | Read strobe |
| reg_rdata | output | 8 | Read data, valid while `reg_rd` is high, else 0 |
| irq_o | output | 1 | Interrupt request to the host |

## Verification
The bench sweeps all 72 source positions through event, summary, interrupt and two-step acknowledge. That sweep exposes three kinds of fault: a wrong group-to-summary mapping (most likely at the shared bit 4 or the shifted bits 5 to 7), a phantom bit in an unused position, and a clear that also wipes neighbouring bits. It drives an event and a clear onto the same bit in the same cycle; a design where the clear wins would drop the bit. It pulses masked sources; a design that gates latching with the mask would lose them. It writes group masks and the read-only summary address; a design whose mask logic touches the summary mask would change that mask or raise `irq_o` when it should not.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
    localparam int SUB_N  = 9;
    localparam int DW     = 8;
    localparam int MAIN_W = 8;

    localparam logic [7:0] ADDR_MAIN  = 8'h00;
    localparam logic [7:0] ADDR_MMASK = 8'h01;
    localparam logic [7:0] STAT_BASE  = 8'h10;
    localparam logic [7:0] MASK_BASE  = 8'h20;

    function automatic int src_width(input int j);
        case (j)
            0: return 7;
            1: return 8;
            2: return 7;
            3: return 3;
            4: return 8;
            5: return 8;
            6: return 2;
            7: return 4;
            default: return 5;
        endcase
    endfunction

    function automatic logic [DW-1:0] used_bits(input int j);
        return DW'((1 << src_width(j)) - 1);
    endfunction

    // summary bit index for each group; bit 4 is shared by groups 4 and 5
    function automatic int group_of(input int j);
        if (j < 4)      return j;
        else if (j < 6) return 4;
        else            return j - 1;
    endfunction
endpackage

// File: rtl/irq_agg_sub_bank.sv
module irq_agg_sub_bank #(
    parameter int DW = 8,
    parameter logic [DW-1:0] USED = '1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [DW-1:0] evt_i,
    input  logic          clr_we,
    input  logic          mask_we,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] stat_o,
    output logic [DW-1:0] mask_o,
    output logic          pend_o
);
    logic [DW-1:0] stat_q, mask_q, evt_used, clr_bits;

    assign evt_used = evt_i & USED;
    assign clr_bits = clr_we ? wdata : '0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stat_q <= '0;
            mask_q <= USED;
        end else begin
            stat_q <= (stat_q & ~clr_bits) | evt_used;
            if (mask_we)
                mask_q <= wdata & USED;
        end
    end

    assign stat_o = stat_q;
    assign mask_o = mask_q;
    assign pend_o = |(stat_q & ~mask_q);

    assert_evt_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_used != '0) |=> ((stat_q & $past(evt_used)) == $past(evt_used)));

    assert_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_we && ((evt_used & wdata) == '0)) |=> ((stat_q & $past(wdata)) == '0));

    assert_unused_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ((stat_q & ~USED) == '0) && ((mask_q & ~USED) == '0));

    assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_we && evt_used == '0) |=> $stable(stat_q));
endmodule

// File: rtl/irq_agg_summary.sv
module irq_agg_summary
    import irq_agg_pkg::*;
#(
    parameter int NSUB  = SUB_N,
    parameter int MW    = MAIN_W
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSUB-1:0] pend_i,
    input  logic            mm_we,
    input  logic [MW-1:0]   wdata,
    output logic [MW-1:0]   main_stat_o,
    output logic [MW-1:0]   main_mask_o,
    output logic            irq_o
);
    logic [MW-1:0] mmask_q, summ;

    always_comb begin
        summ = '0;
        for (int j = 0; j < NSUB; j++)
            summ[group_of(j)] = summ[group_of(j)] | pend_i[j];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            mmask_q <= '1;
        else if (mm_we)
            mmask_q <= wdata;
    end

    assign main_stat_o = summ;
    assign main_mask_o = mmask_q;
    assign irq_o       = |(summ & ~mmask_q);

    assert_mmask_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !mm_we |=> $stable(mmask_q));

    assert_irq_blocked_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (mmask_q == '1) |-> !irq_o);

    assert_irq_needs_pend_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_i == '0) |-> !irq_o);
endmodule

// File: rtl/irq_agg_top.sv
module irq_agg_top
    import irq_agg_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic [SUB_N*DW-1:0] evt_i,
    input  logic [7:0]          reg_addr,
    input  logic                reg_wr,
    input  logic [7:0]          reg_wdata,
    input  logic                reg_rd,
    output logic [7:0]          reg_rdata,
    output logic                irq_o
);
    logic [SUB_N-1:0]  pend;
    logic [DW-1:0]     stat_v [SUB_N];
    logic [DW-1:0]     mask_v [SUB_N];
    logic [MAIN_W-1:0] main_stat, main_mask;

    for (genvar j = 0; j < SUB_N; j++) begin : g_sub
        logic hit_stat, hit_mask;
        assign hit_stat = reg_wr && (reg_addr == 8'(STAT_BASE + j));
        assign hit_mask = reg_wr && (reg_addr == 8'(MASK_BASE + j));

        irq_agg_sub_bank #(.DW(DW), .USED(used_bits(j))) u_bank (
            .clk     (clk),
            .rst_n   (rst_n),
            .evt_i   (evt_i[j*DW +: DW]),
            .clr_we  (hit_stat),
            .mask_we (hit_mask),
            .wdata   (reg_wdata),
            .stat_o  (stat_v[j]),
            .mask_o  (mask_v[j]),
            .pend_o  (pend[j])
        );
    end

    irq_agg_summary u_summary (
        .clk         (clk),
        .rst_n       (rst_n),
        .pend_i      (pend),
        .mm_we       (reg_wr && reg_addr == ADDR_MMASK),
        .wdata       (reg_wdata),
        .main_stat_o (main_stat),
        .main_mask_o (main_mask),
        .irq_o       (irq_o)
    );

    always_comb begin
        reg_rdata = '0;
        if (reg_rd) begin
            if (reg_addr == ADDR_MAIN)  reg_rdata = main_stat;
            if (reg_addr == ADDR_MMASK) reg_rdata = main_mask;
            for (int j = 0; j < SUB_N; j++) begin
                if (reg_addr == 8'(STAT_BASE + j)) reg_rdata = stat_v[j];
                if (reg_addr == 8'(MASK_BASE + j)) reg_rdata = mask_v[j];
            end
        end
    end

    assert_rdata_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_rd |-> (reg_rdata == '0));
endmodule

// File: tb/irq_agg_top_bench.sv
module irq_agg_top_bench;
    logic        clk = 0;
    logic        rst_n = 0;
    logic [71:0] evt_i = '0;
    logic [7:0]  reg_addr = '0;
    logic        reg_wr = 0;
    logic [7:0]  reg_wdata = '0;
    logic        reg_rd = 0;
    logic [7:0]  reg_rdata;
    logic        irq_o;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    always #2 clk = ~clk;

    irq_agg_top u_irq_agg_top (.*);

    function automatic int width_of(input int j);
        int w [9] = '{7, 8, 7, 3, 8, 8, 2, 4, 5};
        return w[j];
    endfunction

    function automatic int grp(input int j);
        return (j < 4) ? j : (j < 6) ? 4 : j - 1;
    endfunction

    function automatic logic [7:0] used(input int j);
        return 8'((1 << width_of(j)) - 1);
    endfunction

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1;
        @(negedge clk);
        reg_wr = 0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [7:0] d);
        reg_addr = a; reg_rd = 1;
        #1 d = reg_rdata;
        reg_rd = 0;
    endtask

    task automatic pulse(input int idx);
        @(negedge clk);
        evt_i[idx] = 1;
        @(negedge clk);
        evt_i = '0;
    endtask

    initial begin
        #200000;
        if (!done) begin
            checks++; failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [7:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);

        // R1 / R9 reset values
        rd(8'h00, d); chk("R1 main", d, 8'h00);
        rd(8'h01, d); chk("R1 main mask", d, 8'hFF);
        chk("R1 irq", {7'd0, irq_o}, 8'h00);
        for (int j = 0; j < 9; j++) begin
            rd(8'(8'h10 + j), d); chk("R1 status", d, 8'h00);
            rd(8'(8'h20 + j), d); chk("R3 mask used bits", d, used(j));
        end
        rd(8'h50, d); chk("R9 unmapped", d, 8'h00);

        // sweep: every source position, summary mask open
        wr(8'h01, 8'h00);
        for (int j = 0; j < 9; j++) begin
            wr(8'(8'h20 + j), 8'h00);
            for (int b = 0; b < 8; b++) begin
                logic [7:0] exp_s, exp_m;
                exp_s = used(j) & 8'(1 << b);
                exp_m = (exp_s != 0) ? 8'(1 << grp(j)) : 8'h00;
                pulse(j * 8 + b);
                rd(8'(8'h10 + j), d); chk("R2 R3 status", d, exp_s);
                rd(8'h00, d);         chk("R6 main", d, exp_m);
                chk("R7 irq", {7'd0, irq_o}, {7'd0, exp_m != 0});
                wr(8'(8'h10 + j), ~8'(1 << b));
                rd(8'(8'h10 + j), d); chk("R4 keep zero-written", d, exp_s);
                wr(8'(8'h10 + j), 8'(1 << b));
                rd(8'(8'h10 + j), d); chk("R4 clear", d, 8'h00);
            end
            wr(8'(8'h20 + j), 8'hFF);
        end

        // R2 masked event still latches; summary and irq quiet
        pulse(8 * 4 + 3);
        rd(8'h14, d); chk("R2 masked latch", d, 8'h08);
        rd(8'h00, d); chk("R6 masked main", d, 8'h00);
        chk("R7 masked irq", {7'd0, irq_o}, 8'h00);
        // unmask group 5 only: shared bit 4 from the other group
        pulse(8 * 5 + 1);
        wr(8'h25, 8'h00);
        rd(8'h00, d); chk("R6 shared bit4", d, 8'h10);
        wr(8'h24, 8'h00);
        wr(8'h15, 8'h02);
        rd(8'h00, d); chk("R6 shared bit4 other group", d, 8'h10);
        wr(8'h14, 8'hFF);
        rd(8'h00, d); chk("R6 bit4 cleared", d, 8'h00);

        // R5 collision: event and clear on same bit same cycle
        pulse(2);
        @(negedge clk);
        evt_i[2] = 1; reg_addr = 8'h10; reg_wdata = 8'h04; reg_wr = 1;
        @(negedge clk);
        evt_i = '0; reg_wr = 0;
        rd(8'h10, d); chk("R5 collision", d, 8'h04);
        wr(8'h10, 8'h04);

        // R10 / R8 GPIO group gated by summary mask bit 6
        wr(8'h01, 8'hFF);
        wr(8'h27, 8'h00);
        pulse(8 * 7 + 2);
        rd(8'h00, d); chk("R10 main bit6", d, 8'h40);
        chk("R10 irq blocked", {7'd0, irq_o}, 8'h00);
        wr(8'h27, 8'h0F);
        wr(8'h27, 8'h00);
        rd(8'h01, d); chk("R8 mmask untouched by group mask", d, 8'hFF);
        wr(8'h00, 8'h00);
        rd(8'h00, d); chk("R8 main read-only", d, 8'h40);
        rd(8'h01, d); chk("R8 mmask after main write", d, 8'hFF);
        wr(8'h01, 8'hBF);
        chk("R10 irq enabled", {7'd0, irq_o}, 8'h01);
        wr(8'h01, 8'h40);
        chk("R7 other mask bits irrelevant", {7'd0, irq_o}, 8'h00);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule